// File: doc/BRIEF.md
# Vector complex integer adder

This block treats a packed vector as an array of complex integers and adds to it a second vector that has been turned by a quarter turn in the complex plane. Within each pair of neighbouring elements, the lower one is the real part and the upper one is the imaginary part. Adding the second operand turned by +90 degrees or by +270 degrees swaps that operand's real and imaginary parts. It also sets the sign of each swapped part.

The element width is chosen at run time from four sizes. Each element sum can either wrap or clamp to the signed range of the element. The caller presents both operands with a valid strobe. One cycle later the block returns the result vector and a flag that shows whether any element was clamped. In the surrounding datapath, the result is written back over the first operand.

Top module: `vec_cplx_add`

## Requirements
- R1: Elements pair up as (2k, 2k+1): element 2k is the real part and element 2k+1 is the imaginary part. Each pair's result depends only on that pair's two operand pairs.
- R2: With `rot270` low (90 degrees), the real result is a_re - b_im and the imaginary result is a_im + b_re.
- R3: With `rot270` high (270 degrees), the real result is a_re + b_im and the imaginary result is a_im - b_re.
- R4: `elem_sz` selects the element width as 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. Element k occupies bits [k*W +: W], and all elements are signed two's complement.
- R5: With `sat_en` low, each element result wraps modulo 2^W.
- R6: With `sat_en` high, each element result is clamped to the range -2^(W-1) .. 2^(W-1)-1.
- R7: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` is updated only on an accepted input and holds otherwise.
- R8: `sat_flag` is recomputed on every accepted input. It is 1 when at least one element of that operation was clamped, and 0 otherwise (it is always 0 in wrapping mode). It holds between accepted inputs.
- R9: A synchronous active-low reset clears `out_valid`, `result` and `sat_flag`, even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| vec_a | input | VEC_W | First operand (accumulator) vector |
| vec_b | input | VEC_W | Second operand vector, rotated before the add |
| elem_sz | input | 2 | Element width code |
| rot270 | input | 1 | 0: rotate by 90 degrees, 1: rotate by 270 degrees |
| sat_en | input | 1 | 1: saturating, 0: wrapping |
| out_valid | output | 1 | Result is valid |
| result | output | VEC_W | Result vector |
| sat_flag | output | 1 | At least one element clamped in the last operation |

## Verification
Random operand vectors are run at every element size, in both rotations and both arithmetic modes. They separate the two sign patterns of the rotations, show whether real and imaginary parts are swapped, and show whether carries leak across element or pair boundaries.

Directed vectors place the most negative value as the real part against a positive imaginary second operand, and the most positive value as the imaginary part against a positive real second operand. These run at each width in both modes, and show wrap against clamp and the flag at each width's boundary.

Idle cycles and a reset asserted while a strobe is high check that the output holds and that reset takes priority.

// File: rtl/cplx_add_pkg.sv
// Shared definitions for the vector complex integer adder.
// Assumes element widths are 8 << code for a two-bit size code.
package cplx_add_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } elem_sz_e;

    localparam int NUM_SIZES = 4;

    // Width in bits of the element selected by a size code.
    function automatic int sz_bits(input int code);
        return 8 << code;
    endfunction
endpackage

// File: rtl/cplx_elem_addsub.sv
// One signed element add or subtract with optional clamping.
// Assumes both inputs are W-bit two's complement values. The clamp output
// is high only when saturation is enabled and the exact result left range.
module cplx_elem_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         do_sub,
    input  logic         sat_en,
    output logic [W-1:0] res,
    output logic         clamp
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W:0] ext_a, ext_b, exact;
    logic       ovf;

    // Exact sum or difference in one extra bit, then wrap or clamp.
    always_comb begin
        ext_a = {opa[W-1], opa};
        ext_b = {opb[W-1], opb};
        exact = do_sub ? (ext_a - ext_b) : (ext_a + ext_b);
        ovf   = exact[W] ^ exact[W-1];
        clamp = sat_en & ovf;
        if (clamp) res = exact[W] ? MINV : MAXV;
        else       res = exact[W-1:0];
    end
endmodule

// File: rtl/cplx_pair.sv
// One complex element pair: adds the rotated second operand to the first.
// 90 degrees: re = a_re - b_im, im = a_im + b_re; 270 degrees: signs swap.
module cplx_pair #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_re,
    input  logic [W-1:0] a_im,
    input  logic [W-1:0] b_re,
    input  logic [W-1:0] b_im,
    input  logic         rot270,
    input  logic         sat_en,
    output logic [W-1:0] y_re,
    output logic [W-1:0] y_im,
    output logic         clamp
);
    logic clamp_re, clamp_im;

    // Real part takes the second operand's imaginary part.
    cplx_elem_addsub #(.W(W)) u_re (
        .opa(a_re), .opb(b_im), .do_sub(~rot270), .sat_en(sat_en),
        .res(y_re), .clamp(clamp_re)
    );

    // Imaginary part takes the second operand's real part.
    cplx_elem_addsub #(.W(W)) u_im (
        .opa(a_im), .opb(b_re), .do_sub(rot270), .sat_en(sat_en),
        .res(y_im), .clamp(clamp_im)
    );

    assign clamp = clamp_re | clamp_im;
endmodule

// File: rtl/cplx_size_path.sv
// All complex pairs of the vector for one fixed element width W.
// Assumes VEC_W is a multiple of 2*W so that every pair fits.
module cplx_size_path #(
    parameter int VEC_W = 128,
    parameter int W     = 8
) (
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    input  logic             rot270,
    input  logic             sat_en,
    output logic [VEC_W-1:0] vec_y,
    output logic             clamp_any
);
    localparam int NPAIR = VEC_W / (2 * W);

    logic [NPAIR-1:0] pair_clamp;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int RE_LO = 2 * p * W;
        localparam int IM_LO = RE_LO + W;
        cplx_pair #(.W(W)) u_pair (
            .a_re  (vec_a[RE_LO +: W]),
            .a_im  (vec_a[IM_LO +: W]),
            .b_re  (vec_b[RE_LO +: W]),
            .b_im  (vec_b[IM_LO +: W]),
            .rot270(rot270),
            .sat_en(sat_en),
            .y_re  (vec_y[RE_LO +: W]),
            .y_im  (vec_y[IM_LO +: W]),
            .clamp (pair_clamp[p])
        );
    end

    assign clamp_any = |pair_clamp;
endmodule

// File: rtl/vec_cplx_add.sv
// Vector complex integer adder, top level.
// Builds one datapath per element width, selects one with the size code and
// registers the result one cycle after in_valid. Assumes VEC_W is a
// multiple of 128. The reset is synchronous and active low.
module vec_cplx_add #(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    input  logic [1:0]       elem_sz,
    input  logic             rot270,
    input  logic             sat_en,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             sat_flag
);
    import cplx_add_pkg::*;

    logic [VEC_W-1:0] y_per_sz [NUM_SIZES];
    logic [NUM_SIZES-1:0] clamp_per_sz;
    logic [VEC_W-1:0] y_sel;
    logic             clamp_sel;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        cplx_size_path #(.VEC_W(VEC_W), .W(sz_bits(s))) u_path (
            .vec_a    (vec_a),
            .vec_b    (vec_b),
            .rot270   (rot270),
            .sat_en   (sat_en),
            .vec_y    (y_per_sz[s]),
            .clamp_any(clamp_per_sz[s])
        );
    end

    // Pick the datapath that matches the requested element width.
    always_comb begin
        y_sel     = y_per_sz[elem_sz];
        clamp_sel = clamp_per_sz[elem_sz];
    end

    // Output register: valid follows the strobe, data loads on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= y_sel;
                sat_flag <= clamp_sel;
            end
        end
    end

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sat_flag));

    // R8
    flag_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !sat_en |=> !sat_flag);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !sat_flag && result == '0);
endmodule

// File: tb/vec_cplx_add_tb_top.sv
`timescale 1ns/1ps
module vec_cplx_add_tb_top;
    localparam int VEC_W = 128;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [VEC_W-1:0] vec_a = '0;
    logic [VEC_W-1:0] vec_b = '0;
    logic [1:0]       elem_sz = 2'd0;
    logic             rot270 = 1'b0;
    logic             sat_en = 1'b0;
    logic             out_valid;
    logic [VEC_W-1:0] result;
    logic             sat_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic             exp_valid = 1'b0;
    logic [VEC_W-1:0] exp_res   = '0;
    logic             exp_flag  = 1'b0;

    always #2 clk = ~clk;

    vec_cplx_add #(.VEC_W(VEC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .vec_a(vec_a), .vec_b(vec_b), .elem_sz(elem_sz),
        .rot270(rot270), .sat_en(sat_en),
        .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
    );

    // Reference for one element operation, using exact wide integers.
    function automatic logic [63:0] ref_elem(input logic [63:0] a, input logic [63:0] b,
                                             input bit sub, input bit sat, input int w,
                                             output bit hit);
        logic signed [63:0] ta, tb;
        logic signed [65:0] sa, sb, r, mx, mn;
        logic [63:0] mask;
        ta = $signed(a << (64 - w)); ta = ta >>> (64 - w);
        tb = $signed(b << (64 - w)); tb = tb >>> (64 - w);
        sa = 66'(ta); sb = 66'(tb);
        mx = (66'sd1 <<< (w - 1)) - 66'sd1;
        mn = -(66'sd1 <<< (w - 1));
        r = sub ? sa - sb : sa + sb;
        hit = 1'b0;
        if (sat && r > mx) begin r = mx; hit = 1'b1; end
        if (sat && r < mn) begin r = mn; hit = 1'b1; end
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        return r[63:0] & mask;
    endfunction

    // Reference for a whole vector operation.
    task automatic ref_vec(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                           input logic [1:0] sz, input bit rot, input bit sat,
                           output logic [VEC_W-1:0] y, output logic flag);
        int w = 8 << sz;
        logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        bit h1, h2;
        y = '0; flag = 1'b0;
        for (int e = 0; e < VEC_W / w; e += 2) begin
            logic [63:0] ar, ai, br, bi, yr, yi;
            ar = 64'(a >> (e * w)) & mask;
            ai = 64'(a >> ((e + 1) * w)) & mask;
            br = 64'(b >> (e * w)) & mask;
            bi = 64'(b >> ((e + 1) * w)) & mask;
            yr = ref_elem(ar, bi, !rot, sat, w, h1);
            yi = ref_elem(ai, br, rot, sat, w, h2);
            y = y | (VEC_W'(yr) << (e * w)) | (VEC_W'(yi) << ((e + 1) * w));
            flag = flag | h1 | h2;
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [VEC_W-1:0] act,
                         input logic [VEC_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle, advance the model at the edge, compare at the next negedge.
    task automatic step(input bit rst, input bit v, input logic [VEC_W-1:0] a,
                        input logic [VEC_W-1:0] b, input logic [1:0] sz,
                        input bit rot, input bit sat, input string tag);
        logic [VEC_W-1:0] y;
        logic f;
        rst_n = rst; in_valid = v; vec_a = a; vec_b = b;
        elem_sz = sz; rot270 = rot; sat_en = sat;
        @(posedge clk);
        #1;
        if (!rst) begin
            exp_valid = 1'b0; exp_res = '0; exp_flag = 1'b0;
        end else begin
            exp_valid = v;
            if (v) begin
                ref_vec(a, b, sz, rot, sat, y, f);
                exp_res = y; exp_flag = f;
            end
        end
        @(negedge clk);
        check(out_valid === exp_valid, "R7 out_valid", VEC_W'(out_valid), VEC_W'(exp_valid));
        check(result === exp_res, tag, result, exp_res);
        check(sat_flag === exp_flag, "R8 sat_flag", VEC_W'(sat_flag), VEC_W'(exp_flag));
    endtask

    // Fill every pair at one size with the same real and imaginary values.
    function automatic logic [VEC_W-1:0] fill(input logic [1:0] sz, input logic [63:0] re,
                                              input logic [63:0] im);
        int w = 8 << sz;
        logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        logic [VEC_W-1:0] v = '0;
        for (int e = 0; e < VEC_W / w; e += 2)
            v = v | (VEC_W'(re & mask) << (e * w)) | (VEC_W'(im & mask) << ((e + 1) * w));
        return v;
    endfunction

    function automatic logic [VEC_W-1:0] rnd_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [63:0] mn, mx;
        @(negedge clk);
        // R9: reset with a strobe present
        step(1'b0, 1'b1, rnd_vec(), rnd_vec(), 2'd0, 1'b0, 1'b1, "R9 reset result");
        step(1'b0, 1'b0, '0, '0, 2'd0, 1'b0, 1'b0, "R9 reset result");
        // R1 R2 R3 R4: random data at all sizes and both rotations
        for (int i = 0; i < 64; i++) begin
            bit rot = i[0];
            step(1'b1, 1'b1, rnd_vec(), rnd_vec(), 2'(i >> 1), rot, i[3],
                 rot ? "R3 rot270 R1 R4" : "R2 rot90 R1 R4");
        end
        // R7: idle cycles hold the last result
        step(1'b1, 1'b0, rnd_vec(), rnd_vec(), 2'd1, 1'b0, 1'b1, "R7 hold");
        step(1'b1, 1'b0, rnd_vec(), rnd_vec(), 2'd2, 1'b1, 1'b0, "R7 hold");
        // R5 R6: range boundaries at every size, both modes and rotations
        for (int s = 0; s < 4; s++) begin
            int w = 8 << s;
            mx = (w == 64) ? 64'h7fff_ffff_ffff_ffff : ((64'd1 << (w - 1)) - 64'd1);
            mn = ~mx;
            for (int m = 0; m < 2; m++) begin
                // most negative real minus positive imaginary (90 degrees)
                step(1'b1, 1'b1, fill(2'(s), mn, 64'd5), fill(2'(s), 64'd3, 64'd1),
                     2'(s), 1'b0, m[0], m[0] ? "R6 min-1 clamp" : "R5 min-1 wrap");
                // most positive imaginary plus positive real (90 degrees)
                step(1'b1, 1'b1, fill(2'(s), 64'd0, mx), fill(2'(s), 64'd1, 64'd2),
                     2'(s), 1'b0, m[0], m[0] ? "R6 max+1 clamp" : "R5 max+1 wrap");
                // most positive real plus positive imaginary (270 degrees)
                step(1'b1, 1'b1, fill(2'(s), mx, 64'd0), fill(2'(s), 64'd0, 64'd7),
                     2'(s), 1'b1, m[0], m[0] ? "R6 rot270 clamp" : "R5 rot270 wrap");
                // most negative imaginary minus positive real (270 degrees)
                step(1'b1, 1'b1, fill(2'(s), 64'd1, mn), fill(2'(s), 64'd9, 64'd0),
                     2'(s), 1'b1, m[0], m[0] ? "R6 rot270 min clamp" : "R5 rot270 min wrap");
            end
            // R8: a clean saturating operation clears the flag
            step(1'b1, 1'b1, fill(2'(s), 64'd1, 64'd2), fill(2'(s), 64'd3, 64'd4),
                 2'(s), 1'b0, 1'b1, "R8 flag clears");
        end
        // R9: reset mid-run clears a loaded result
        step(1'b1, 1'b1, rnd_vec(), rnd_vec(), 2'd3, 1'b0, 1'b0, "R9 preload");
        step(1'b0, 1'b1, rnd_vec(), rnd_vec(), 2'd0, 1'b0, 1'b1, "R9 reset result");
        step(1'b1, 1'b0, '0, '0, 2'd0, 1'b0, 1'b0, "R9 after reset");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule